// File: doc/BRIEF.md
# Flagged Eight-Bit Shift and Rotate Unit

This block shifts or rotates one data byte by a variable count. It returns the moved value at once, with three condition flags: carry, zero and negative. One 3-bit select picks among six kinds of move: left and right logical shifts, left and right arithmetic shifts, and left and right rotates without carry. The count comes either from a short immediate field or from a full data register. The select input chooses which one.

The datapath is combinational. Only one bit of state exists: the held carry flag. A zero count passes the operand through unchanged and presents the held carry again. A one-cycle `exec` strobe commits the current carry output into the held flag at the next rising clock edge. The block therefore fits into an execute stage where the instruction fires for a single cycle.

Top module: `shift_rot_unit`

## Requirements
- R1: The `op` encoding is fixed: 0 logical left, 1 logical right, 2 arithmetic left, 3 arithmetic right, 4 rotate left, 5 rotate right. Codes 6 and 7 return the operand unchanged and present the held carry on `flag_c`.
- R2: With `amt_sel`=0 the count is `amt_imm` (0 to 7). With `amt_sel`=1 the count is the whole `amt_reg` byte (0 to 255).
- R3: A count of zero gives `result` equal to `operand` for every code, and `flag_c` equal to the held carry.
- R4: Logical and arithmetic left shifts by k (k≥1) fill from the right with zeros. `flag_c` is operand bit 8−k for k≤8. From k≥8 the result is all zeros, and `flag_c` is 0 for k>8.
- R5: A logical right shift by k fills from the top with zeros. `flag_c` is operand bit k−1 for k≤8 and 0 for k>8. From k≥8 the result is zero.
- R6: An arithmetic right shift by k copies operand bit 7 into every vacated position. `flag_c` is operand bit k−1 for k≤8 and operand bit 7 for k>8.
- R7: Rotates move the bits by k mod 8, so a nonzero multiple of 8 restores the operand. `flag_c` is the last bit carried around: result bit 0 for rotate left and result bit 7 for rotate right, and this also holds when k mod 8 is 0.
- R8: `flag_z` is 1 exactly when `result` is zero. `flag_n` equals `result` bit 7.
- R9: Reset clears the held carry to 0. When `exec` is high at a rising edge, the held carry takes the value `flag_c` had before that edge. Otherwise the held carry stays unchanged.
- R10: For operand 11001010 and count 1, the outputs are: logical left 10010100 with C=1; logical right 01100101 with C=0; arithmetic right 11100101 with C=0; rotate left 10010101 with C=1; rotate right 01100101 with C=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the held carry flag |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Commit `flag_c` into the held carry at the next edge |
| op | input | 3 | Operation code (see R1) |
| amt_sel | input | 1 | Count source: 0 immediate, 1 register |
| amt_imm | input | 3 | Immediate count |
| amt_reg | input | 8 | Register-sourced count, used in full |
| operand | input | 8 | Data byte to move |
| result | output | 8 | Moved data byte |
| flag_c | output | 1 | Last bit moved out, or held carry for a zero count |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 7 |

## Verification
The clocked properties sample the combinational inputs at the rising edge. They therefore assume that `op`, the count fields, `operand` and `exec` stay steady from shortly after one falling edge until after the following rising edge. They also assume that `exec` is low while reset is applied. The stimulus changes every input just after a falling edge and holds it through the next rising edge, and it keeps `exec` low during reset. It covers every code, every immediate count and the register counts 8, 9, 15, 16 and 200 over a spread of operands.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Encoding of the operation select; values are part of the interface.
    typedef enum logic [2:0] {
        OP_LSL  = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASL  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } shf_op_e;

endpackage

// File: rtl/shf_amount.sv
// Picks the count source and derives a saturated shift count, a rotate
// count (low bits only) and a raw zero indication.
module shf_amount #(
    parameter int DW = 8
) (
    input  logic                     amt_sel,
    input  logic [$clog2(DW)-1:0]    amt_imm,
    input  logic [DW-1:0]            amt_reg,
    output logic [$clog2(DW):0]      sh_amt,
    output logic [$clog2(DW)-1:0]    rot_amt,
    output logic                     amt_zero
);
    localparam int IMM_W = $clog2(DW);
    localparam int CNT_W = IMM_W + 1;

    logic reg_high;

    // Any bit at or above CNT_W means the count is far beyond the width.
    assign reg_high = |amt_reg[DW-1:CNT_W];

    always_comb begin
        if (amt_sel) begin
            sh_amt   = reg_high ? '1 : amt_reg[CNT_W-1:0];
            rot_amt  = amt_reg[IMM_W-1:0];
            amt_zero = (amt_reg == '0);
        end else begin
            sh_amt   = {1'b0, amt_imm};
            rot_amt  = amt_imm;
            amt_zero = (amt_imm == '0);
        end
    end

endmodule

// File: rtl/shf_core.sv
// Combinational move datapath: result and carry for every operation.
module shf_core
    import shf_pkg::*;
#(
    parameter int DW = 8
) (
    input  shf_op_e                  op,
    input  logic [DW-1:0]            operand,
    input  logic [$clog2(DW):0]      sh_amt,
    input  logic [$clog2(DW)-1:0]    rot_amt,
    input  logic                     amt_zero,
    input  logic                     c_hold,
    output logic [DW-1:0]            result,
    output logic                     c_next
);
    localparam int IMM_W = $clog2(DW);
    localparam int CNT_W = IMM_W + 1;
    localparam logic [CNT_W-1:0] DW_CNT = CNT_W'(DW);

    logic [DW:0]        left_ext;
    logic [DW:0]        right_ext;
    logic signed [DW:0] arith_ext;
    logic [DW-1:0]      rot_left;
    logic [DW-1:0]      rot_right;
    logic [CNT_W-1:0]   rot_inv;

    // One guard bit beyond the data catches the last bit moved out.
    assign left_ext  = {1'b0, operand} << sh_amt;
    assign right_ext = {operand, 1'b0} >> sh_amt;
    assign arith_ext = $signed({operand, 1'b0}) >>> sh_amt;

    assign rot_inv   = DW_CNT - {1'b0, rot_amt};
    assign rot_left  = (operand << rot_amt) | (operand >> rot_inv);
    assign rot_right = (operand >> rot_amt) | (operand << rot_inv);

    always_comb begin
        result = operand;
        c_next = c_hold;
        if (!amt_zero) begin
            unique case (op)
                OP_LSL, OP_ASL: begin
                    result = left_ext[DW-1:0];
                    c_next = left_ext[DW];
                end
                OP_LSR: begin
                    result = right_ext[DW:1];
                    c_next = right_ext[0];
                end
                OP_ASR: begin
                    result = arith_ext[DW:1];
                    c_next = arith_ext[0];
                end
                OP_ROL: begin
                    result = rot_left;
                    c_next = rot_left[0];
                end
                OP_ROR: begin
                    result = rot_right;
                    c_next = rot_right[DW-1];
                end
                OP_RSV6, OP_RSV7: begin
                    result = operand;
                    c_next = c_hold;
                end
            endcase
        end
    end

endmodule

// File: rtl/shf_cflag.sv
// Held carry flag: cleared by reset, loaded on a commit strobe.
module shf_cflag (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic c_in,
    output logic c_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= 1'b0;
        end else if (load) begin
            c_q <= c_in;
        end
    end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import shf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  exec,
    input  logic [2:0]            op,
    input  logic                  amt_sel,
    input  logic [$clog2(DW)-1:0] amt_imm,
    input  logic [DW-1:0]         amt_reg,
    input  logic [DW-1:0]         operand,
    output logic [DW-1:0]         result,
    output logic                  flag_c,
    output logic                  flag_z,
    output logic                  flag_n
);
    localparam int IMM_W = $clog2(DW);
    localparam int CNT_W = IMM_W + 1;

    logic [CNT_W-1:0] sh_amt;
    logic [IMM_W-1:0] rot_amt;
    logic             amt_zero;
    logic             c_held;

    shf_amount #(.DW(DW)) u_amount (
        .amt_sel  (amt_sel),
        .amt_imm  (amt_imm),
        .amt_reg  (amt_reg),
        .sh_amt   (sh_amt),
        .rot_amt  (rot_amt),
        .amt_zero (amt_zero)
    );

    shf_core #(.DW(DW)) u_core (
        .op       (shf_op_e'(op)),
        .operand  (operand),
        .sh_amt   (sh_amt),
        .rot_amt  (rot_amt),
        .amt_zero (amt_zero),
        .c_hold   (c_held),
        .result   (result),
        .c_next   (flag_c)
    );

    shf_cflag u_cflag (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (exec),
        .c_in  (flag_c),
        .c_q   (c_held)
    );

    assign flag_z = (result == '0);
    assign flag_n = result[DW-1];

endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
    parameter int DW = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  exec,
    input logic [2:0]            op,
    input logic                  amt_sel,
    input logic [$clog2(DW)-1:0] amt_imm,
    input logic [DW-1:0]         amt_reg,
    input logic [DW-1:0]         operand,
    input logic [DW-1:0]         result,
    input logic                  flag_c,
    input logic                  flag_z,
    input logic                  flag_n,
    input logic                  c_held
);
    logic cnt_zero;
    assign cnt_zero = amt_sel ? (amt_reg == '0) : (amt_imm == '0);

    assert_zero_count_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_zero |-> (result == operand && flag_c == c_held));

    assert_reserved_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op >= 3'd6) |-> (result == operand && flag_c == c_held));

    assert_left_low_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 3'd0 || op == 3'd2) && !cnt_zero) |-> !result[0]);

    assert_lsr_top_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1 && !cnt_zero) |-> !result[DW-1]);

    assert_asr_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3) |-> (result[DW-1] == operand[DW-1]));

    assert_rotate_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4 || op == 3'd5) |-> ($countones(result) == $countones(operand)));

    assert_zn_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_z, flag_n}));

    assert_commit_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> (c_held == $past(flag_c)));

    assert_hold_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(c_held));

endmodule

bind shift_rot_unit shift_rot_unit_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec    (exec),
    .op      (op),
    .amt_sel (amt_sel),
    .amt_imm (amt_imm),
    .amt_reg (amt_reg),
    .operand (operand),
    .result  (result),
    .flag_c  (flag_c),
    .flag_z  (flag_z),
    .flag_n  (flag_n),
    .c_held  (c_held)
);

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec = 1'b0;
    logic [2:0] op = 3'd0;
    logic       amt_sel = 1'b0;
    logic [2:0] amt_imm = 3'd0;
    logic [7:0] amt_reg = 8'd0;
    logic [7:0] operand = 8'd0;
    logic [7:0] result;
    logic       flag_c, flag_z, flag_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic model_c = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_rot_unit u_shift_rot_unit (
        .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .amt_sel(amt_sel),
        .amt_imm(amt_imm), .amt_reg(amt_reg), .operand(operand),
        .result(result), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n)
    );

    // Behavioural reference: apply the move one bit position at a time.
    function automatic void model(input int code, input int k, input logic [7:0] a,
                                  input logic cin, output logic [7:0] r, output logic c);
        r = a;
        c = cin;
        if (k == 0 || code >= 6) return;
        for (int i = 0; i < k; i++) begin
            case (code)
                0, 2: begin c = r[7]; r = {r[6:0], 1'b0}; end
                1:    begin c = r[0]; r = {1'b0, r[7:1]}; end
                3:    begin c = r[0]; r = {r[7], r[7:1]}; end
                4:    begin c = r[7]; r = {r[6:0], r[7]}; end
                default: begin c = r[0]; r = {r[0], r[7:1]}; end
            endcase
        end
    endfunction

    function automatic string tag_of(input int code, input int k);
        if (k == 0) return "R3";
        case (code)
            0, 2: return "R4";
            1:    return "R5";
            3:    return "R6";
            4, 5: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic step(input string tag, input int code, input bit sel, input int k,
                        input logic [7:0] a, input bit do_exec);
        logic [7:0] er;
        logic ec;
        @(negedge clk);
        op      = code[2:0];
        amt_sel = sel;
        amt_imm = sel ? 3'd5 : k[2:0];
        amt_reg = sel ? k[7:0] : 8'hA7;
        operand = a;
        exec    = do_exec;
        #1;
        model(code, k, a, model_c, er, ec);
        checks++;
        if (result !== er || flag_c !== ec || flag_z !== (er == 8'd0) || flag_n !== er[7]) begin
            fails++;
            $display("FAIL %s: op=%0d k=%0d a=%b got r=%b c=%b z=%b n=%b expected r=%b c=%b z=%b n=%b",
                     tag, code, k, a, result, flag_c, flag_z, flag_n,
                     er, ec, (er == 8'd0), er[7]);
        end
        @(posedge clk);
        if (do_exec) model_c = ec;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [6] = '{8'hCA, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h5A};
        int reg_cnts [5] = '{8, 9, 15, 16, 200};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset leaves the held carry at 0, visible through a zero count
        step("R9", 0, 0, 0, 8'hFF, 0);

        // R10: worked example for each kind, count 1
        step("R10", 0, 0, 1, 8'b11001010, 1);
        step("R10", 1, 0, 1, 8'b11001010, 1);
        step("R10", 2, 0, 1, 8'b11001010, 1);
        step("R10", 3, 0, 1, 8'b11001010, 1);
        step("R10", 4, 0, 1, 8'b11001010, 1);
        step("R10", 5, 0, 1, 8'b11001010, 1);

        // R9: commit a 1, drop a 0 without exec, zero count shows the 1
        step("R9", 0, 0, 1, 8'hCA, 1);
        step("R9", 1, 0, 1, 8'hCA, 0);
        step("R9", 3, 0, 0, 8'h11, 0);

        // R2: same count from both sources, register count beyond immediate range
        step("R2", 3, 0, 3, 8'h96, 0);
        step("R2", 3, 1, 3, 8'h96, 0);
        step("R2", 1, 1, 8, 8'h80, 1);

        // R8: zero result sets Z, negative result sets N
        step("R8", 0, 0, 1, 8'h80, 0);
        step("R8", 5, 0, 1, 8'h01, 0);

        // R1: reserved codes pass through with held carry
        step("R1", 6, 0, 4, 8'h3C, 0);
        step("R1", 7, 1, 9, 8'hC3, 0);

        // Sweep every code, operand and count
        for (int code = 0; code < 8; code++) begin
            for (int p = 0; p < 6; p++) begin
                for (int k = 0; k < 8; k++)
                    step(tag_of(code, k), code, 0, k, pats[p], (k % 2) == 1);
                for (int j = 0; j < 5; j++)
                    step(tag_of(code, reg_cnts[j]), code, 1, reg_cnts[j], pats[p], j == 2);
                step("R3", code, 1, 0, pats[p], 0);
            end
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule